// File: doc/BRIEF.md
# Distinguished-Point Filter and Ring Feeder

This block closes the loop of a circular, fully pipelined random-walk engine. Every cycle, one slot comes back from the tail of the iteration ring. A slot is a valid flag plus a triple: a 113-bit point coordinate pair (x, y) and two 113-bit scalars (c, d). The block decides what re-enters the ring head. If the returning slot is occupied, it passes straight through. If the slot is empty and the host has staged a triple, the staged triple is loaded into it. After one injection per stage, the ring holds as many triples as it has stages, and every stage does useful work on every cycle.

A returning triple is distinguished when the top bits of its x-coordinate are all zero. A copy of each distinguished triple goes into an on-chip FIFO store, and the triple itself stays in the ring. The host drains the store at its own pace through a slow register port while the ring keeps running. Inside this block, the iteration arithmetic is stood in for by a fixed-latency delay line.

Top module: `dp_feeder`

## Requirements
- R1: An asynchronous active-low reset `rst_ni` clears the following: every ring slot becomes inactive, and the staging flag, store count, reject flag and overflow flag all go to zero.
- R2: When the slot returning from the ring tail is inactive and the staging register is full, the staged triple enters the ring at that edge and `stage_full_o` reads 0 after it.
- R3: While the returning slot is active, the staging register is not consumed. Once STAGES triples circulate, a staged triple stays pending indefinitely.
- R4: A returning active triple is distinguished when bits [112:83] of x are all zero, and it is pushed into the store one edge after it reaches the ring tail. A triple whose x has any of those 30 bits set is not stored.
- R5: A distinguished triple keeps circulating after it is copied, so it is stored again once every STAGES cycles.
- R6: The store holds at most STORE_DEPTH (128) entries. A distinguished triple that arrives while the count is 128 is dropped, and the sticky `dp_ovf_o` flag is set.
- R7: A pulse on `status_clr_i` clears `dp_ovf_o` and `stage_rej_o`. A new overflow or rejection in the same cycle takes priority over the clear.
- R8: A word write (`stage_we_i`) or a commit (`stage_commit_i`) made while `stage_full_o` is 1 is ignored and sets the sticky `stage_rej_o`. The triple that is already staged enters the ring unchanged.
- R9: `rd_data_o` shows a word of the oldest stored entry. `rd_sel_i` selects the word: 0 selects x, 1 selects y, 2 selects c and 3 selects d. A `rd_pop_i` pulse advances to the next entry in arrival order. A pop on an empty store is ignored.
- R10: `dp_count_o` equals the number of stored entries. It rises by one per accepted push and falls by one per pop on a non-empty store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stage_we_i | input | 1 | Write one word of the staging triple |
| stage_sel_i | input | 2 | Staging word select: 0 x, 1 y, 2 c, 3 d |
| stage_data_i | input | 113 | Staging write data |
| stage_commit_i | input | 1 | Mark the staged triple ready for injection |
| stage_full_o | output | 1 | Staged triple waiting for an empty slot |
| stage_rej_o | output | 1 | Sticky: a write or commit hit a full staging register |
| rd_sel_i | input | 2 | Store read word select: 0 x, 1 y, 2 c, 3 d |
| rd_pop_i | input | 1 | Release the oldest stored entry |
| rd_data_o | output | 113 | Selected word of the oldest stored entry |
| dp_count_o | output | 8 | Number of stored distinguished triples |
| dp_ovf_o | output | 1 | Sticky: a distinguished triple was dropped |
| status_clr_i | input | 1 | Clear both sticky flags |

## Verification
A table of x-coordinates probes the boundary of the zero-prefix test, including a value with only bit 83 set and one with only bit 82 set. A design that miscounts the prefix by one bit will store or drop the wrong one of these. Exact-cycle checks on the store count catch a design that stores injected starting points instead of returned results, or one that removes a distinguished triple from the ring so that it does not come back a lap later. Filling the ring shows whether the design overwrites circulating work with a new triple. A write landing in the one cycle between commit and injection catches staging that is corrupted by host writes. Running the store past 128 entries, draining part of it and clearing the flags shows whether the design wraps and overwrites old entries, or loses the overflow flag.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int unsigned WORD_W = 113;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t x;
    word_t y;
    word_t c;
    word_t d;
  } triple_t;

  typedef struct packed {
    logic    vld;
    triple_t t;
  } slot_t;

  typedef enum logic [1:0] {
    SEL_X = 2'd0,
    SEL_Y = 2'd1,
    SEL_C = 2'd2,
    SEL_D = 2'd3
  } word_sel_e;

  function automatic word_t pick_word(triple_t t, logic [1:0] sel);
    word_t w;
    case (word_sel_e'(sel))
      SEL_X:   w = t.x;
      SEL_Y:   w = t.y;
      SEL_C:   w = t.c;
      default: w = t.d;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/dp_delay_line.sv
module dp_delay_line
  import dp_pkg::*;
#(
  parameter int unsigned STAGES = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  slot_t in_i,
  output slot_t out_o
);
  slot_t q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[0] <= '0;
        else         q[0] <= in_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[i] <= '0;
        else         q[i] <= q[i-1];
      end
    end
  end

  assign out_o = q[STAGES-1];
endmodule

// File: rtl/dp_staging.sv
module dp_staging
  import dp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  sel_i,
  input  word_t       data_i,
  input  logic        commit_i,
  input  logic        take_i,
  input  logic        clr_i,
  output logic        full_o,
  output logic        rej_o,
  output triple_t     trip_o
);
  triple_t trip_q;
  logic    full_q, rej_q;
  logic    bad_access;

  assign bad_access = (we_i || commit_i) && full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= '0;
      full_q <= 1'b0;
    end else if (full_q) begin
      if (take_i) full_q <= 1'b0;
    end else begin
      if (we_i) begin
        case (word_sel_e'(sel_i))
          SEL_X:   trip_q.x <= data_i;
          SEL_Y:   trip_q.y <= data_i;
          SEL_C:   trip_q.c <= data_i;
          default: trip_q.d <= data_i;
        endcase
      end
      if (commit_i) full_q <= 1'b1;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rej_q <= 1'b0;
    else if (bad_access) rej_q <= 1'b1;
    else if (clr_i)      rej_q <= 1'b0;
  end

  assign full_o = full_q;
  assign rej_o  = rej_q;
  assign trip_o = trip_q;
endmodule

// File: rtl/dp_store.sv
module dp_store
  import dp_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  triple_t       din_i,
  input  logic          pop_i,
  input  logic [1:0]    sel_i,
  input  logic          clr_i,
  output word_t         rd_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  triple_t       mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic          ovf_q;
  logic          is_full, do_push, do_pop, drop;

  assign is_full = (count_q == CW'(DEPTH));
  assign do_push = push_i && !is_full;
  assign drop    = push_i && is_full;
  assign do_pop  = pop_i && (count_q != '0);

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ovf_q <= 1'b0;
    else if (drop)  ovf_q <= 1'b1;
    else if (clr_i) ovf_q <= 1'b0;
  end

  assign rd_o    = pick_word(mem[rd_ptr], sel_i);
  assign count_o = count_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/dp_feeder.sv
module dp_feeder
  import dp_pkg::*;
#(
  parameter int unsigned STAGES      = 8,
  parameter int unsigned STORE_DEPTH = 128,
  parameter int unsigned ZERO_BITS   = 30,
  localparam int unsigned CNT_W      = $clog2(STORE_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stage_we_i,
  input  logic [1:0]       stage_sel_i,
  input  logic [112:0]     stage_data_i,
  input  logic             stage_commit_i,
  output logic             stage_full_o,
  output logic             stage_rej_o,
  input  logic [1:0]       rd_sel_i,
  input  logic             rd_pop_i,
  output logic [112:0]     rd_data_o,
  output logic [CNT_W-1:0] dp_count_o,
  output logic             dp_ovf_o,
  input  logic             status_clr_i
);
  slot_t   tail, head;
  triple_t staged;
  word_t   tail_x;
  logic    tail_vld, inject, is_dist;

  assign tail_vld = tail.vld;
  assign tail_x   = tail.t.x;
  assign inject   = !tail_vld && stage_full_o;
  assign is_dist  = tail_vld && (tail_x[WORD_W-1 -: ZERO_BITS] == '0);

  always_comb begin
    head = tail;
    if (inject) head = '{vld: 1'b1, t: staged};
  end

  dp_delay_line #(.STAGES(STAGES)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (head),
    .out_o  (tail)
  );

  dp_staging u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (stage_we_i),
    .sel_i    (stage_sel_i),
    .data_i   (stage_data_i),
    .commit_i (stage_commit_i),
    .take_i   (inject),
    .clr_i    (status_clr_i),
    .full_o   (stage_full_o),
    .rej_o    (stage_rej_o),
    .trip_o   (staged)
  );

  dp_store #(.DEPTH(STORE_DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (is_dist),
    .din_i   (tail.t),
    .pop_i   (rd_pop_i),
    .sel_i   (rd_sel_i),
    .clr_i   (status_clr_i),
    .rd_o    (rd_data_o),
    .count_o (dp_count_o),
    .ovf_o   (dp_ovf_o)
  );
endmodule

// File: rtl/dp_feeder_chk.sv
module dp_feeder_chk #(
  parameter int unsigned W     = 113,
  parameter int unsigned ZB    = 30,
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tail_vld,
  input logic [W-1:0]  tail_x,
  input logic          full,
  input logic          rej,
  input logic          we,
  input logic          commit,
  input logic          pop,
  input logic          clr,
  input logic [CW-1:0] cnt,
  input logic          ovf
);
  logic arrive_dist;
  assign arrive_dist = tail_vld && (tail_x[W-1 -: ZB] == '0);

  p_inject_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && !tail_vld |=> !full);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && tail_vld |=> full);

  p_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arrive_dist && (cnt < CW'(DEPTH)) && !pop |=> cnt == CW'($past(cnt) + 1'b1));

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arrive_dist && !pop |=> $stable(cnt));

  p_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf && !clr |=> ovf);

  p_clr_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && !(arrive_dist && cnt == CW'(DEPTH)) |=> !ovf);

  p_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we || commit) && full |=> rej);

  p_empty_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == '0 && pop && !arrive_dist |=> cnt == '0);
endmodule

bind dp_feeder dp_feeder_chk #(
  .W(dp_pkg::WORD_W), .ZB(ZERO_BITS), .DEPTH(STORE_DEPTH), .CW(CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tail_vld (tail_vld),
  .tail_x   (tail_x),
  .full     (stage_full_o),
  .rej      (stage_rej_o),
  .we       (stage_we_i),
  .commit   (stage_commit_i),
  .pop      (rd_pop_i),
  .clr      (status_clr_i),
  .cnt      (dp_count_o),
  .ovf      (dp_ovf_o)
);

// File: tb/sim_dp_feeder.sv
module sim_dp_feeder;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int NV = 7;

  localparam logic [112:0] VX [NV] = '{
    113'h1234,
    {1'b1, 112'h0},
    113'(1) << 83,
    113'(1) << 82,
    113'h0,
    {113{1'b1}},
    {30'h0, {83{1'b1}}}
  };
  localparam int VEXP [NV] = '{1, 0, 0, 1, 1, 0, 1};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0, commit = 1'b0, pop = 1'b0, clr = 1'b0;
  logic [1:0]   sel = 2'd0, rsel = 2'd0;
  logic [112:0] data = '0;
  logic         full, rej, ovf;
  logic [112:0] rdata;
  logic [7:0]   cnt;
  int           n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_feeder u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .stage_we_i(we), .stage_sel_i(sel), .stage_data_i(data),
    .stage_commit_i(commit), .stage_full_o(full), .stage_rej_o(rej),
    .rd_sel_i(rsel), .rd_pop_i(pop), .rd_data_o(rdata),
    .dp_count_o(cnt), .dp_ovf_o(ovf), .status_clr_i(clr)
  );

  task automatic tick(int k = 1);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic check(string tag, logic [112:0] act, logic [112:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; we = 0; commit = 0; pop = 0; clr = 0;
    tick(2);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic put_word(logic [1:0] s, logic [112:0] d);
    we = 1'b1; sel = s; data = d;
    tick();
    we = 1'b0;
  endtask

  // returns at the negedge right after the commit edge
  task automatic stage(logic [112:0] x);
    for (int i = 0; i < 100 && full; i++) tick();
    put_word(2'd0, x);
    put_word(2'd1, x ^ 113'hA5A5);
    put_word(2'd2, x + 113'd7);
    put_word(2'd3, ~x);
    commit = 1'b1;
    tick();
    commit = 1'b0;
  endtask

  function automatic logic [112:0] rd(logic [1:0] s);
    return '0;
  endfunction

  task automatic read_word(logic [1:0] s, output logic [112:0] v);
    rsel = s;
    #1;
    v = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [112:0] v;
    do_reset();
    // R1 reset state
    check("R1 count", 113'(cnt), 113'd0);
    check("R1 full", 113'(full), 113'd0);
    check("R1 rej", 113'(rej), 113'd0);
    check("R1 ovf", 113'(ovf), 113'd0);

    // R4 prefix table, with R2 injection, R9 read order, R5 lap, R10 pop
    for (int k = 0; k < NV; k++) begin
      do_reset();
      stage(VX[k]);
      check("R2 staged", 113'(full), 113'd1);
      tick();
      check("R2 injected", 113'(full), 113'd0);
      tick(N - 1);
      check("R4 before arrival", 113'(cnt), 113'd0);
      tick();
      check("R4 stored", 113'(cnt), 113'(VEXP[k]));
      if (VEXP[k] == 1) begin
        read_word(2'd0, v); check("R9 x", v, VX[k]);
        read_word(2'd1, v); check("R9 y", v, VX[k] ^ 113'hA5A5);
        read_word(2'd2, v); check("R9 c", v, VX[k] + 113'd7);
        read_word(2'd3, v); check("R9 d", v, ~VX[k]);
        tick(N);
        check("R5 second lap", 113'(cnt), 113'd2);
        pop = 1'b1; tick(); pop = 1'b0;
        check("R10 pop", 113'(cnt), 113'd1);
      end
    end

    // R9 pop on empty store
    do_reset();
    pop = 1'b1; tick(); pop = 1'b0;
    check("R9 empty pop", 113'(cnt), 113'd0);

    // R3 ring full blocks injection
    do_reset();
    for (int i = 0; i < N; i++) stage({1'b1, 112'(i)});
    stage({1'b1, 112'hFF});
    tick(3 * N);
    check("R3 pending", 113'(full), 113'd1);
    check("R4 nondist", 113'(cnt), 113'd0);
    put_word(2'd0, 113'h0);
    check("R8 reject", 113'(rej), 113'd1);
    clr = 1'b1; tick(); clr = 1'b0;
    check("R7 rej clear", 113'(rej), 113'd0);

    // R8 write in the cycle between commit and injection
    do_reset();
    stage(113'h55);
    we = 1'b1; sel = 2'd0; data = 113'h99; commit = 1'b1;
    tick();
    we = 1'b0; commit = 1'b0;
    check("R8 rej set", 113'(rej), 113'd1);
    check("R8 commit ignored", 113'(full), 113'd0);
    tick(N);
    check("R8 stored", 113'(cnt), 113'd1);
    read_word(2'd0, v);
    check("R8 x intact", v, 113'h55);

    // R6 overflow, R9 FIFO order, R7 ovf clear
    do_reset();
    stage(113'h1);
    stage(113'h2);
    tick(80 * N);
    check("R6 capped", 113'(cnt), 113'd128);
    check("R6 ovf", 113'(ovf), 113'd1);
    read_word(2'd0, v); check("R9 first", v, 113'h1);
    pop = 1'b1; tick(); pop = 1'b0;
    read_word(2'd0, v); check("R9 second", v, 113'h2);
    pop = 1'b1; tick(10); pop = 1'b0;
    clr = 1'b1; tick(); clr = 1'b0;
    check("R7 ovf clear", 113'(ovf), 113'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule